// File: doc/BRIEF.md
# Dual-Image Configuration Loader

This block is the power-up sequencer that moves a configuration bitstream from a byte-wide parallel flash into an FPGA's passive-parallel configuration port. The flash holds two images. One is a user image and the other is a factory fallback. After reset the loader tries the user image. If that attempt fails, it makes one attempt with the factory image.

Each attempt has four steps. First the loader drives the target's configuration-request line low for a fixed time. It then waits for the target's status line to go high. Next it streams the image one byte per configuration clock. Finally it checks the target's done line. The configuration clock is the system clock divided down by a parameter, so the target's timing limits hold even with a fast system clock.

A strap can force the factory image. An active-low reload input restarts the whole sequence. A second strap can block that input, so a loaded design that holds the line low by mistake cannot cause endless reloads.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_ni` is low, `cfg_nconfig_o` is low and `done_o`, `cfg_dclk_o` and `flash_rd_o` are all low.
- R2: Each attempt begins with `cfg_nconfig_o` low for at least `NCFG_CYC` cycles. While it is low there are no flash reads and no configuration clock edges.
- R3: After `cfg_nconfig_o` rises, no configuration clock edge occurs until `cfg_nstatus_i` has been seen high.
- R4: An attempt sends the `IMG_BYTES` bytes of the selected image in ascending address order. The user image starts at flash byte address 0x080000 and the factory image at 0x0C0000. Read data returns one cycle after `flash_rd_o`. Each byte is on `cfg_data_o` and stable at the rising edge of `cfg_dclk_o`.
- R5: If `cfg_conf_done_i` is high once the last byte has been clocked, `done_o` rises and stays high. `done_o` only means the transfer completed.
- R6: If `cfg_conf_done_i` is still low after the last user-image byte, the loader retries with the factory image.
- R7: If `cfg_nstatus_i` goes low while the user image is streaming, the loader stops that stream and retries with the factory image.
- R8: With `force_factory_i` high at reset, only the factory image is sent.
- R9: If the factory attempt also fails, the loader halts. `done_o` stays low, no flash reads occur, and reload requests are ignored until the next reset.
- R10: With `reload_en_i` high, a falling edge on `reload_ni` drops `done_o` and restarts the full sequence with the user image.
- R11: With `reload_en_i` low, `reload_ni` has no effect. `done_o` stays high and `cfg_nconfig_o` does not pulse.
- R12: `cfg_dclk_o` stays high for exactly `HALF_CYC` cycles per byte and stays low for at least `HALF_CYC` cycles between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| reload_ni | input | 1 | Active-low reload request, asynchronous, idles high |
| reload_en_i | input | 1 | Strap: 1 lets the reload request act |
| force_factory_i | input | 1 | Strap: 1 skips the user image |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_addr_o | output | ADDR_W | Flash byte address |
| flash_data_i | input | 8 | Flash read data, valid one cycle after the strobe |
| cfg_nconfig_o | output | 1 | Active-low configuration request to the target |
| cfg_nstatus_i | input | 1 | Target status, low means reset or error |
| cfg_conf_done_i | input | 1 | Target reports configuration complete |
| cfg_dclk_o | output | 1 | Divided configuration clock |
| cfg_data_o | output | 8 | Configuration byte |
| done_o | output | 1 | Transfer finished |

## Verification
The hardest situation to reach is a status error in the middle of the user stream, followed by a clean factory load. The bench reaches it with a target model that pulls `cfg_nstatus_i` low right after the third user byte. The scoreboard skips the partial user bytes, identified by the image bit of the address being read, and expects the complete factory image afterwards. A double failure is set up by withholding `cfg_conf_done_i` for both images. The bench then watches the flash strobe across a window that includes a reload pulse.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [3:0] {
    ST_INIT,
    ST_PULSE,
    ST_WAIT,
    ST_READ,
    ST_LOAD,
    ST_LO,
    ST_HI,
    ST_CHECK,
    ST_DONE,
    ST_ERR
  } cfgl_state_e;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cfgl_timer.sv
// Counts while enabled; hit_o marks the LIMIT-th cycle and restarts the count.
module cfgl_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i || hit_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/cfgl_addr.sv
module cfgl_addr #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned USER_BASE = 32'h080000,
  parameter int unsigned FACT_BASE = 32'h0C0000,
  parameter int unsigned IMG_BYTES = 262144
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              factory_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              factory_o
);
  localparam int unsigned OW = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1;

  logic [OW-1:0] off_q;
  logic          fact_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      off_q  <= '0;
      fact_q <= 1'b0;
    end else if (load_i) begin
      off_q  <= '0;
      fact_q <= factory_i;
    end else if (inc_i) begin
      off_q  <= off_q + 1'b1;
    end

  assign addr_o    = (fact_q ? ADDR_W'(FACT_BASE) : ADDR_W'(USER_BASE)) + ADDR_W'(off_q);
  assign last_o    = (off_q == OW'(IMG_BYTES - 1));
  assign factory_o = fact_q;
endmodule

// File: rtl/cfgl_fsm.sv
module cfgl_fsm
  import cfgl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nstatus_i,
  input  logic conf_done_i,
  input  logic force_factory_i,
  input  logic reload_evt_i,
  input  logic pulse_hit_i,
  input  logic half_hit_i,
  input  logic last_i,
  input  logic factory_i,
  output logic load_o,
  output logic load_factory_o,
  output logic inc_o,
  output logic rd_o,
  output logic latch_o,
  output logic pulse_en_o,
  output logic half_en_o,
  output logic nconfig_o,
  output logic dclk_o,
  output logic done_o
);
  cfgl_state_e state_q, nxt;
  logic        fail, streaming;
  logic        nconfig_q, dclk_q;

  assign streaming = (state_q == ST_READ) || (state_q == ST_LOAD) ||
                     (state_q == ST_LO)   || (state_q == ST_HI);

  always_comb begin
    nxt            = state_q;
    load_o         = 1'b0;
    load_factory_o = 1'b0;
    inc_o          = 1'b0;
    fail           = 1'b0;
    case (state_q)
      ST_INIT: begin
        load_o         = 1'b1;
        load_factory_o = force_factory_i;
        nxt            = ST_PULSE;
      end
      ST_PULSE: if (pulse_hit_i) nxt = ST_WAIT;
      ST_WAIT:  if (nstatus_i) nxt = ST_READ;
      ST_READ:  nxt = ST_LOAD;
      ST_LOAD:  nxt = ST_LO;
      ST_LO:    if (half_hit_i) nxt = ST_HI;
      ST_HI: if (half_hit_i) begin
        if (last_i) nxt = ST_CHECK;
        else begin
          inc_o = 1'b1;
          nxt   = ST_READ;
        end
      end
      ST_CHECK: if (conf_done_i) nxt = ST_DONE;
                else             fail = 1'b1;
      ST_DONE, ST_ERR: nxt = state_q;
      default: nxt = ST_ERR;
    endcase

    // target flagged an error mid-stream
    if (streaming && !nstatus_i) begin
      fail  = 1'b1;
      inc_o = 1'b0;
    end

    if (fail) begin
      if (factory_i) nxt = ST_ERR;
      else begin
        load_o         = 1'b1;
        load_factory_o = 1'b1;
        nxt            = ST_PULSE;
      end
    end

    if (reload_evt_i && (state_q != ST_ERR) && (state_q != ST_INIT)) begin
      load_o         = 1'b1;
      load_factory_o = force_factory_i;
      inc_o          = 1'b0;
      nxt            = ST_PULSE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q   <= ST_INIT;
      nconfig_q <= 1'b0;
      dclk_q    <= 1'b0;
    end else begin
      state_q   <= nxt;
      nconfig_q <= !((nxt == ST_INIT) || (nxt == ST_PULSE));
      dclk_q    <= (nxt == ST_HI);
    end

  assign rd_o       = (state_q == ST_READ);
  assign latch_o    = (state_q == ST_LOAD);
  assign pulse_en_o = (state_q == ST_PULSE);
  assign half_en_o  = (state_q == ST_LO) || (state_q == ST_HI);
  assign nconfig_o  = nconfig_q;
  assign dclk_o     = dclk_q;
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned USER_BASE   = 32'h080000,
  parameter int unsigned FACT_BASE   = 32'h0C0000,
  parameter int unsigned IMG_BYTES   = 262144,
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned NCFG_CYC    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_ni,
  input  logic              reload_en_i,
  input  logic              force_factory_i,
  output logic              flash_rd_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  input  logic [7:0]        flash_data_i,
  output logic              cfg_nconfig_o,
  input  logic              cfg_nstatus_i,
  input  logic              cfg_conf_done_i,
  output logic              cfg_dclk_o,
  output logic [7:0]        cfg_data_o,
  output logic              done_o
);
  logic rl_s, rl_d_q, reload_evt;
  logic load, load_factory, inc, latch, last, factory;
  logic pulse_en, pulse_hit, half_en, half_hit;
  logic [7:0] byte_q;

  cfgl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(reload_ni), .q_o(rl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rl_d_q <= 1'b1;
    else         rl_d_q <= rl_s;

  assign reload_evt = rl_d_q && !rl_s && reload_en_i;

  cfgl_timer #(.LIMIT(NCFG_CYC)) u_pulse_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pulse_en), .hit_o(pulse_hit)
  );

  cfgl_timer #(.LIMIT(HALF_CYC)) u_half_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(half_en), .hit_o(half_hit)
  );

  cfgl_addr #(
    .ADDR_W(ADDR_W), .USER_BASE(USER_BASE), .FACT_BASE(FACT_BASE), .IMG_BYTES(IMG_BYTES)
  ) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .factory_i(load_factory),
    .inc_i(inc), .addr_o(flash_addr_o), .last_o(last), .factory_o(factory)
  );

  cfgl_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .nstatus_i(cfg_nstatus_i), .conf_done_i(cfg_conf_done_i),
    .force_factory_i(force_factory_i), .reload_evt_i(reload_evt),
    .pulse_hit_i(pulse_hit), .half_hit_i(half_hit), .last_i(last), .factory_i(factory),
    .load_o(load), .load_factory_o(load_factory), .inc_o(inc),
    .rd_o(flash_rd_o), .latch_o(latch), .pulse_en_o(pulse_en), .half_en_o(half_en),
    .nconfig_o(cfg_nconfig_o), .dclk_o(cfg_dclk_o), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    byte_q <= '0;
    else if (latch) byte_q <= flash_data_i;

  assign cfg_data_o = byte_q;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned USER_BASE = 32'h080000,
  parameter int unsigned FACT_BASE = 32'h0C0000,
  parameter int unsigned IMG_BYTES = 262144
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flash_rd_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic              cfg_nconfig_o,
  input logic              cfg_dclk_o,
  input logic [7:0]        cfg_data_o,
  input logic              cfg_conf_done_i,
  input logic              done_o
);
  localparam logic [ADDR_W-1:0] U_LO = ADDR_W'(USER_BASE);
  localparam logic [ADDR_W-1:0] U_HI = ADDR_W'(USER_BASE + IMG_BYTES - 1);
  localparam logic [ADDR_W-1:0] F_LO = ADDR_W'(FACT_BASE);
  localparam logic [ADDR_W-1:0] F_HI = ADDR_W'(FACT_BASE + IMG_BYTES - 1);

  assert_pulse_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_nconfig_o |-> (!cfg_dclk_o && !flash_rd_o));

  assert_dclk_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_dclk_o) |-> cfg_nconfig_o);

  assert_addr_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_o |-> ((flash_addr_o >= U_LO && flash_addr_o <= U_HI) ||
                    (flash_addr_o >= F_LO && flash_addr_o <= F_HI)));

  assert_done_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cfg_conf_done_i));

  assert_done_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cfg_nconfig_o && !flash_rd_o && !cfg_dclk_o));

  assert_data_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_dclk_o) |-> $stable(cfg_data_o));
endmodule

bind cfg_loader cfgl_checker #(
  .ADDR_W(ADDR_W), .USER_BASE(USER_BASE), .FACT_BASE(FACT_BASE), .IMG_BYTES(IMG_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flash_rd_o(flash_rd_o), .flash_addr_o(flash_addr_o),
  .cfg_nconfig_o(cfg_nconfig_o), .cfg_dclk_o(cfg_dclk_o), .cfg_data_o(cfg_data_o),
  .cfg_conf_done_i(cfg_conf_done_i), .done_o(done_o)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned UBASE  = 32'h080000;
  localparam int unsigned FBASE  = 32'h0C0000;
  localparam int unsigned IMG    = 16;
  localparam int unsigned HALF   = 2;
  localparam int unsigned NCFG   = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, reload_ni = 1'b1;
  logic reload_en_i = 1'b1, force_factory_i = 1'b0;
  logic flash_rd_o;
  logic [ADDR_W-1:0] flash_addr_o;
  logic [7:0] flash_data_i = '0;
  logic cfg_nconfig_o, cfg_dclk_o, done_o;
  logic [7:0] cfg_data_o;
  logic cfg_nstatus_i = 1'b0, cfg_conf_done_i = 1'b0;

  always #4 clk_i = ~clk_i;

  cfg_loader #(
    .ADDR_W(ADDR_W), .USER_BASE(UBASE), .FACT_BASE(FBASE), .IMG_BYTES(IMG),
    .HALF_CYC(HALF), .NCFG_CYC(NCFG), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_ni(reload_ni), .reload_en_i(reload_en_i),
    .force_factory_i(force_factory_i), .flash_rd_o(flash_rd_o), .flash_addr_o(flash_addr_o),
    .flash_data_i(flash_data_i), .cfg_nconfig_o(cfg_nconfig_o), .cfg_nstatus_i(cfg_nstatus_i),
    .cfg_conf_done_i(cfg_conf_done_i), .cfg_dclk_o(cfg_dclk_o), .cfg_data_o(cfg_data_o),
    .done_o(done_o)
  );

  int checks = 0, errs = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] img_byte(logic [ADDR_W-1:0] a);
    return a[7:0] ^ (a[18] ? 8'hA5 : 8'h3C);
  endfunction

  logic [7:0] exp_q[$];
  logic [7:0] exp_b;

  task automatic push_image(int unsigned base);
    for (int i = 0; i < IMG; i++) exp_q.push_back(img_byte(ADDR_W'(base + i)));
  endtask

  // flash model: one-cycle read latency
  logic cur_img = 1'b0;
  always @(posedge clk_i)
    if (flash_rd_o) begin
      flash_data_i <= img_byte(flash_addr_o);
      cur_img      <= flash_addr_o[18];
    end

  // target model and scoreboard monitor
  bit user_ok = 1, fact_ok = 1, fault_user = 0, ignore_user = 0;
  int st_delay = 5;
  int rx = 0, st_cnt = 0, low_cnt = 0, hi_cnt = 0, lo_cnt = 0, rd_cnt = 0, fall_cnt = 0;
  bit faulted = 0, p_ncfg = 0, p_dclk = 0, p_ns = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      cfg_nstatus_i = 0; cfg_conf_done_i = 0; rx = 0; st_cnt = 0; low_cnt = 0;
      hi_cnt = 0; lo_cnt = 0; faulted = 0; p_ncfg = 0; p_dclk = 0; p_ns = 0;
    end else begin
      if (flash_rd_o) rd_cnt++;
      p_ns = cfg_nstatus_i;
      if (!cfg_nconfig_o) begin
        if (p_ncfg) fall_cnt++;
        low_cnt++;
        cfg_nstatus_i = 0; cfg_conf_done_i = 0; rx = 0; st_cnt = 0; faulted = 0; lo_cnt = 0;
      end else begin
        if (!p_ncfg) begin
          chk(low_cnt >= NCFG, "R2", "nconfig low cycles", low_cnt, NCFG);
          low_cnt = 0;
        end
        if (cfg_dclk_o && !p_dclk) begin
          chk(p_ns, "R3", "status high before dclk", p_ns, 1);
          if (rx > 0) chk(lo_cnt >= HALF, "R12", "dclk low cycles", lo_cnt, HALF);
          rx++; hi_cnt = 0; lo_cnt = 0;
          if (!(ignore_user && !cur_img)) begin
            if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", cfg_data_o, 0);
            else begin
              exp_b = exp_q.pop_front();
              chk(cfg_data_o == exp_b, "R4", "config byte", cfg_data_o, exp_b);
            end
          end
          if (fault_user && !cur_img && rx == 3) faulted = 1;
          if (rx == IMG && (cur_img ? fact_ok : user_ok)) cfg_conf_done_i = 1;
        end
        if (!cfg_dclk_o && p_dclk && p_ns)
          chk(hi_cnt == HALF, "R12", "dclk high cycles", hi_cnt, HALF);
        if (faulted) cfg_nstatus_i = 0;
        else if (st_cnt < st_delay) st_cnt++;
        else cfg_nstatus_i = 1;
        if (cfg_dclk_o) hi_cnt++; else lo_cnt++;
      end
      p_ncfg = cfg_nconfig_o;
      p_dclk = cfg_dclk_o;
    end
  end

  task automatic do_reset(bit ff, bit ren);
    rst_ni = 0; force_factory_i = ff; reload_en_i = ren;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim && !done_o; i++) @(negedge clk_i);
  endtask

  task automatic pulse_reload();
    reload_ni = 0;
    repeat (4) @(negedge clk_i);
    reload_ni = 1;
  endtask

  initial begin
    @(negedge clk_i);
    // R1 reset state
    chk(!cfg_nconfig_o, "R1", "nconfig in reset", cfg_nconfig_o, 0);
    chk(!done_o, "R1", "done in reset", done_o, 0);
    chk(!cfg_dclk_o, "R1", "dclk in reset", cfg_dclk_o, 0);
    chk(!flash_rd_o, "R1", "flash read in reset", flash_rd_o, 0);

    // R4/R5 clean user load
    do_reset(0, 1);
    push_image(UBASE);
    wait_done(2000);
    chk(done_o, "R5", "done after user load", done_o, 1);
    chk(exp_q.size() == 0, "R4", "user bytes left", exp_q.size(), 0);
    repeat (20) @(negedge clk_i);
    chk(done_o, "R5", "done held", done_o, 1);

    // R6 user image never completes
    user_ok = 0; exp_q.delete();
    do_reset(0, 1);
    push_image(UBASE); push_image(FBASE);
    wait_done(2000);
    chk(done_o, "R6", "done after fallback", done_o, 1);
    chk(exp_q.size() == 0, "R6", "bytes left after fallback", exp_q.size(), 0);

    // R7 status error mid user stream
    user_ok = 1; fault_user = 1; ignore_user = 1; exp_q.delete();
    do_reset(0, 1);
    push_image(FBASE);
    wait_done(2000);
    chk(done_o, "R7", "done after status error", done_o, 1);
    chk(exp_q.size() == 0, "R7", "factory bytes left", exp_q.size(), 0);
    fault_user = 0; ignore_user = 0;

    // R8 forced factory
    exp_q.delete();
    do_reset(1, 1);
    push_image(FBASE);
    wait_done(2000);
    chk(done_o, "R8", "done forced factory", done_o, 1);
    chk(exp_q.size() == 0, "R8", "factory bytes left", exp_q.size(), 0);

    // R9 both images fail
    user_ok = 0; fact_ok = 0; exp_q.delete();
    do_reset(0, 1);
    push_image(UBASE); push_image(FBASE);
    repeat (600) @(negedge clk_i);
    chk(!done_o, "R9", "done after double failure", done_o, 0);
    chk(exp_q.size() == 0, "R9", "bytes left", exp_q.size(), 0);
    rd_cnt = 0;
    pulse_reload();
    repeat (100) @(negedge clk_i);
    chk(rd_cnt == 0, "R9", "reads while halted", rd_cnt, 0);
    chk(!done_o, "R9", "done while halted", done_o, 0);

    // R10 reload honoured
    user_ok = 1; fact_ok = 1; exp_q.delete();
    do_reset(0, 1);
    push_image(UBASE);
    wait_done(2000);
    chk(done_o, "R10", "initial load", done_o, 1);
    push_image(UBASE);
    pulse_reload();
    for (int i = 0; i < 10 && done_o; i++) @(negedge clk_i);
    chk(!done_o, "R10", "done dropped on reload", done_o, 0);
    wait_done(2000);
    chk(done_o, "R10", "done after reload", done_o, 1);
    chk(exp_q.size() == 0, "R10", "reload bytes left", exp_q.size(), 0);

    // R11 reload blocked
    exp_q.delete();
    do_reset(0, 0);
    push_image(UBASE);
    wait_done(2000);
    fall_cnt = 0;
    pulse_reload();
    repeat (60) @(negedge clk_i);
    chk(done_o, "R11", "done with reload blocked", done_o, 1);
    chk(fall_cnt == 0, "R11", "nconfig pulses", fall_cnt, 0);
    chk(exp_q.size() == 0, "R11", "bytes left", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL R5 watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule